// File: doc/BRIEF.md
# Cache Write-Back-and-Invalidate Sequencer

This block empties a small three-level cache on command. When a flush request arrives, it walks each line of each level's tag/state store. Every modified line is sent to a memory write-back channel, and the walker waits for an acknowledge before moving on. Once that walk is complete, a second walk marks every line in every level invalid. Lines that are valid but clean, and lines that are already invalid, are never written back. This keeps memory consistent whether a line was held under a write-through policy or a write-back policy.

After the invalidation walk, the sequencer tells caches further down the bus to do the same by issuing special bus cycles. In one-cycle mode it issues a single combined write-back-and-invalidate cycle. In two-cycle mode it issues a write-back cycle followed by an invalidate cycle. The mode input is captured when the flush starts. A one-cycle done pulse marks the end of the operation. Ordinary hits, fills, replacement and snooping are handled by other logic.

Top module: `cache_flush_seq`

## Requirements
- R1: No line of any level is written (`st_we`) while any modified line of the current flush still awaits write-back; all write-backs complete before the first invalidation.
- R2: When `flush_done` pulses, every line of every level holds state 2'b00 (invalid). The state encoding is bit 0 = valid and bit 1 = modified, with 2'b11 meaning modified.
- R3: A write-back request is raised exactly once for each line whose state is 2'b11, and never for a line in state 2'b01 or 2'b00.
- R4: `wb_req` stays high, with `wb_level`, `wb_index` and `wb_tag` stable, until `wb_ack` is seen high at a clock edge. The walker does not advance meanwhile.
- R5: Both walks visit level 0, then level 1, then level 2, and within each level visit indices in ascending order. At most one `st_we` bit is high in any cycle.
- R6: In two-cycle mode (`two_cycle_mode`=1) the special cycles are type 2'b01 (write back) followed by type 2'b10 (invalidate). In one-cycle mode a single cycle of type 2'b11 is issued.
- R7: `sc_valid` stays high, with `sc_type` stable, until `sc_ready` is seen high at a clock edge.
- R8: `flush_done` is high for exactly one cycle, in the cycle after the last special cycle is accepted.
- R9: A `flush_req` that arrives while a flush is in progress has no effect. No second walk follows the first.
- R10: A synchronous `rst` returns the sequencer to idle with all request outputs low, and it writes no line state.
- R11: `two_cycle_mode` is sampled in the cycle the flush request is accepted. Later changes do not alter the current flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_req | input | 1 | Start a flush (sampled while idle) |
| two_cycle_mode | input | 1 | 1: two special cycles, 0: one combined cycle |
| flush_done | output | 1 | One-cycle completion pulse |
| st_idx | output | NUM_LEVELS*IDX_W | Per-level line index for the tag/state port |
| st_state | input | NUM_LEVELS*2 | Per-level state of the addressed line |
| st_tag | input | NUM_LEVELS*TAG_W | Per-level tag of the addressed line |
| st_we | output | NUM_LEVELS | Per-level state write enable |
| st_wstate | output | 2 | State written when `st_we` is high (always invalid) |
| wb_req | output | 1 | Write-back request |
| wb_level | output | LVL_W | Level of the line being written back |
| wb_index | output | IDX_W | Index of the line being written back |
| wb_tag | output | TAG_W | Tag of the line being written back |
| wb_ack | input | 1 | Write-back accepted |
| sc_valid | output | 1 | Special bus cycle valid |
| sc_type | output | 2 | Special cycle type: 01 write back, 10 invalidate, 11 both |
| sc_ready | input | 1 | Special cycle accepted |

## Verification
The in-RTL assertions check, on every cycle, the properties that can be seen locally:
- the write-back and special-cycle handshakes hold their values until accepted;
- the walker steps one line at a time and wraps only at the final line;
- write enables are one-hot and never coincide with a write-back;
- a write-back is raised only for a modified line;
- the done pulse follows an accepted special cycle;
- a second special cycle follows a write-back-type first cycle.

Some behaviours span a whole operation, and only the bench scenarios can show them:
- every line ends up invalid;
- the number of write-backs equals the number of modified lines;
- a late flush request or a mode change is ignored;
- a reset in mid-walk leaves the store untouched.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WB_SCAN,
    S_WB_WAIT,
    S_INV,
    S_SC_FIRST,
    S_SC_SECOND,
    S_DONE
  } phase_e;

  localparam logic [1:0] LINE_INVALID = 2'b00;
  localparam logic [1:0] LINE_DIRTY   = 2'b11;

  localparam logic [1:0] SC_NONE  = 2'b00;
  localparam logic [1:0] SC_WB    = 2'b01;
  localparam logic [1:0] SC_INV   = 2'b10;
  localparam logic [1:0] SC_WBINV = 2'b11;

  // A line needs write-back only when both valid and modified bits are set.
  function automatic logic line_dirty(input logic [1:0] st);
    return st == LINE_DIRTY;
  endfunction

  // Code of the first special cycle for the captured mode.
  function automatic logic [1:0] first_sc_code(input logic two_cycles);
    return two_cycles ? SC_WB : SC_WBINV;
  endfunction

  // Linear position of a line across all levels.
  function automatic int unsigned line_pos(input int unsigned lvl,
                                           input int unsigned idx,
                                           input int unsigned lines);
    return lvl * lines + idx;
  endfunction

endpackage

// File: rtl/cfs_walker.sv
module cfs_walker
  import cfs_pkg::*;
#(
  parameter int NUM_LEVELS = 3,
  parameter int LINES      = 8,
  parameter int LVL_W      = 2,
  parameter int IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [LVL_W-1:0] cur_lvl,
  output logic [IDX_W-1:0] cur_idx,
  output logic             at_last
);

  localparam logic [LVL_W-1:0] LVL_LAST = LVL_W'(NUM_LEVELS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LINES - 1);

  logic idx_wrap;
  assign idx_wrap = (cur_idx == IDX_LAST);
  assign at_last  = idx_wrap && (cur_lvl == LVL_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_lvl <= '0;
      cur_idx <= '0;
    end else if (step) begin
      if (at_last) begin
        cur_lvl <= '0;
        cur_idx <= '0;
      end else if (idx_wrap) begin
        cur_lvl <= cur_lvl + 1'b1;
        cur_idx <= '0;
      end else begin
        cur_idx <= cur_idx + 1'b1;
      end
    end
  end

  int unsigned pos_now;
  assign pos_now = line_pos(int'(cur_lvl), int'(cur_idx), LINES);

  assert_walk_ascending_R5: assert property (@(posedge clk) disable iff (rst)
    (step && !at_last) |=> (pos_now == $past(pos_now) + 1));

  assert_walk_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (step && at_last) |=> (pos_now == 0));

  assert_walk_still_R4: assert property (@(posedge clk) disable iff (rst)
    !step |=> (pos_now == $past(pos_now)));

endmodule

// File: rtl/cfs_ctrl.sv
module cfs_ctrl
  import cfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       flush_req,
  input  logic       two_cycle_mode,
  input  logic       cur_dirty,
  input  logic       at_last,
  input  logic       wb_ack,
  input  logic       sc_ready,
  output logic       step,
  output logic       inv_en,
  output logic       wb_req,
  output logic       sc_valid,
  output logic [1:0] sc_type,
  output logic       flush_done
);

  phase_e state_q, state_d;
  logic   mode_q;
  logic   wb_accept;
  logic   sc_accept;
  logic   start;

  assign wb_accept = wb_req && wb_ack;
  assign sc_accept = sc_valid && sc_ready;
  assign start     = (state_q == S_IDLE) && flush_req;

  always_comb begin
    state_d = state_q;
    step    = 1'b0;
    inv_en  = 1'b0;
    unique case (state_q)
      S_IDLE:      if (flush_req) state_d = S_WB_SCAN;
      S_WB_SCAN: begin
        if (cur_dirty) begin
          state_d = S_WB_WAIT;
        end else begin
          step = 1'b1;
          if (at_last) state_d = S_INV;
        end
      end
      S_WB_WAIT: begin
        if (wb_ack) begin
          step    = 1'b1;
          state_d = at_last ? S_INV : S_WB_SCAN;
        end
      end
      S_INV: begin
        step   = 1'b1;
        inv_en = 1'b1;
        if (at_last) state_d = S_SC_FIRST;
      end
      S_SC_FIRST:  if (sc_ready) state_d = mode_q ? S_SC_SECOND : S_DONE;
      S_SC_SECOND: if (sc_ready) state_d = S_DONE;
      S_DONE:      state_d = S_IDLE;
      default:     state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start) mode_q <= two_cycle_mode;
    end
  end

  assign wb_req     = (state_q == S_WB_WAIT);
  assign sc_valid   = (state_q == S_SC_FIRST) || (state_q == S_SC_SECOND);
  assign flush_done = (state_q == S_DONE);

  always_comb begin
    sc_type = SC_NONE;
    if (state_q == S_SC_FIRST)  sc_type = first_sc_code(mode_q);
    if (state_q == S_SC_SECOND) sc_type = SC_INV;
  end

  assert_sc_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && !sc_ready) |=> (sc_valid && $stable(sc_type)));

  assert_sc_second_R6: assert property (@(posedge clk) disable iff (rst)
    (sc_accept && sc_type == SC_WB) |=> (sc_valid && sc_type == SC_INV));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    flush_done |=> !flush_done);

  assert_done_after_sc_R8: assert property (@(posedge clk) disable iff (rst)
    flush_done |-> $past(sc_accept));

  assert_inv_after_wb_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(inv_en) |-> $past(state_q == S_WB_SCAN || state_q == S_WB_WAIT));

  assert_scan_entry_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_WB_SCAN) |->
      $past(state_q == S_IDLE || state_q == S_WB_SCAN || state_q == S_WB_WAIT));

  assert_wb_progress_R4: assert property (@(posedge clk) disable iff (rst)
    wb_accept |=> !wb_req || (state_q == S_WB_WAIT && $past(!at_last)));

endmodule

// File: rtl/cfs_lineport.sv
module cfs_lineport
  import cfs_pkg::*;
#(
  parameter int NUM_LEVELS = 3,
  parameter int LVL_W      = 2,
  parameter int IDX_W      = 3,
  parameter int TAG_W      = 12
) (
  input  logic [LVL_W-1:0]            cur_lvl,
  input  logic [IDX_W-1:0]            cur_idx,
  input  logic                        inv_en,
  input  logic [NUM_LEVELS*2-1:0]     st_state,
  input  logic [NUM_LEVELS*TAG_W-1:0] st_tag,
  output logic [NUM_LEVELS*IDX_W-1:0] st_idx,
  output logic [NUM_LEVELS-1:0]       st_we,
  output logic [1:0]                  cur_state,
  output logic [TAG_W-1:0]            cur_tag
);

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_level
    logic hit;
    assign hit = (cur_lvl == LVL_W'(l));
    assign st_idx[l*IDX_W +: IDX_W] = hit ? cur_idx : '0;
    assign st_we[l]                 = hit && inv_en;
  end

  always_comb begin
    cur_state = LINE_INVALID;
    cur_tag   = '0;
    for (int l = 0; l < NUM_LEVELS; l++) begin
      if (cur_lvl == LVL_W'(l)) begin
        cur_state = st_state[l*2 +: 2];
        cur_tag   = st_tag[l*TAG_W +: TAG_W];
      end
    end
  end

endmodule

// File: rtl/cache_flush_seq.sv
module cache_flush_seq
  import cfs_pkg::*;
#(
  parameter int NUM_LEVELS = 3,
  parameter int LINES      = 8,
  parameter int TAG_W      = 12,
  parameter int LVL_W      = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1,
  parameter int IDX_W      = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flush_req,
  input  logic                        two_cycle_mode,
  output logic                        flush_done,
  output logic [NUM_LEVELS*IDX_W-1:0] st_idx,
  input  logic [NUM_LEVELS*2-1:0]     st_state,
  input  logic [NUM_LEVELS*TAG_W-1:0] st_tag,
  output logic [NUM_LEVELS-1:0]       st_we,
  output logic [1:0]                  st_wstate,
  output logic                        wb_req,
  output logic [LVL_W-1:0]            wb_level,
  output logic [IDX_W-1:0]            wb_index,
  output logic [TAG_W-1:0]            wb_tag,
  input  logic                        wb_ack,
  output logic                        sc_valid,
  output logic [1:0]                  sc_type,
  input  logic                        sc_ready
);

  logic [LVL_W-1:0] cur_lvl;
  logic [IDX_W-1:0] cur_idx;
  logic             at_last;
  logic             step;
  logic             inv_en;
  logic [1:0]       cur_state;
  logic [TAG_W-1:0] cur_tag;
  logic             cur_dirty;

  assign cur_dirty = line_dirty(cur_state);

  cfs_walker #(
    .NUM_LEVELS(NUM_LEVELS), .LINES(LINES), .LVL_W(LVL_W), .IDX_W(IDX_W)
  ) u_walker (
    .clk(clk), .rst(rst), .step(step),
    .cur_lvl(cur_lvl), .cur_idx(cur_idx), .at_last(at_last)
  );

  cfs_lineport #(
    .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_port (
    .cur_lvl(cur_lvl), .cur_idx(cur_idx), .inv_en(inv_en),
    .st_state(st_state), .st_tag(st_tag),
    .st_idx(st_idx), .st_we(st_we),
    .cur_state(cur_state), .cur_tag(cur_tag)
  );

  cfs_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .flush_req(flush_req), .two_cycle_mode(two_cycle_mode),
    .cur_dirty(cur_dirty), .at_last(at_last),
    .wb_ack(wb_ack), .sc_ready(sc_ready),
    .step(step), .inv_en(inv_en), .wb_req(wb_req),
    .sc_valid(sc_valid), .sc_type(sc_type), .flush_done(flush_done)
  );

  assign st_wstate = LINE_INVALID;
  assign wb_level  = cur_lvl;
  assign wb_index  = cur_idx;
  assign wb_tag    = cur_tag;

  assert_wb_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (wb_req && !wb_ack) |=>
      (wb_req && $stable(wb_level) && $stable(wb_index) && $stable(wb_tag)));

  assert_wb_only_dirty_R3: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> line_dirty(cur_state));

  assert_we_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(st_we));

  assert_no_we_during_wb_R1: assert property (@(posedge clk) disable iff (rst)
    (st_we != '0) |-> !wb_req);

  assert_reset_idle_R10: assert property (@(posedge clk)
    $past(rst) |-> (!wb_req && st_we == '0 && !sc_valid && !flush_done));

endmodule

// File: tb/cache_flush_seq_bench.sv
`timescale 1ns/1ps
module cache_flush_seq_bench;

  localparam int NL    = 3;
  localparam int LN    = 8;
  localparam int TW    = 12;
  localparam int LW    = 2;
  localparam int IW    = 3;
  localparam int TOTAL = NL * LN;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush_req = 1'b0;
  logic two_cycle_mode = 1'b0;
  logic flush_done;
  logic [NL*IW-1:0] st_idx;
  logic [NL*2-1:0]  st_state;
  logic [NL*TW-1:0] st_tag;
  logic [NL-1:0]    st_we;
  logic [1:0]       st_wstate;
  logic wb_req;
  logic [LW-1:0] wb_level;
  logic [IW-1:0] wb_index;
  logic [TW-1:0] wb_tag;
  logic wb_ack = 1'b0;
  logic sc_valid;
  logic [1:0] sc_type;
  logic sc_ready = 1'b0;

  always #10 clk = ~clk;

  cache_flush_seq u_cache_flush_seq (
    .clk(clk), .rst(rst), .flush_req(flush_req), .two_cycle_mode(two_cycle_mode),
    .flush_done(flush_done), .st_idx(st_idx), .st_state(st_state), .st_tag(st_tag),
    .st_we(st_we), .st_wstate(st_wstate), .wb_req(wb_req), .wb_level(wb_level),
    .wb_index(wb_index), .wb_tag(wb_tag), .wb_ack(wb_ack),
    .sc_valid(sc_valid), .sc_type(sc_type), .sc_ready(sc_ready)
  );

  // Tag/state store owned by the bench.
  logic [1:0]    mem_st  [TOTAL];
  logic [TW-1:0] mem_tag [TOTAL];

  always_comb begin
    for (int l = 0; l < NL; l++) begin
      st_state[l*2 +: 2]  = mem_st[l*LN + int'(st_idx[l*IW +: IW])];
      st_tag[l*TW +: TW]  = mem_tag[l*LN + int'(st_idx[l*IW +: IW])];
    end
  end

  always @(posedge clk) begin
    for (int l = 0; l < NL; l++)
      if (st_we[l]) mem_st[l*LN + int'(st_idx[l*IW +: IW])] <= st_wstate;
  end

  int total = 0;
  int fails = 0;
  bit checking = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase number and a linear line pointer.
  int ph = 0;
  int p = 0;
  bit mode_m = 0;

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; p = 0;
    end else begin
      case (ph)
        0: if (flush_req) begin ph = 1; p = 0; mode_m = two_cycle_mode; end
        1: if (mem_st[p] == 2'b11) ph = 2;
           else if (p == TOTAL-1) begin ph = 3; p = 0; end
           else p++;
        2: if (wb_ack) begin
             if (p == TOTAL-1) begin ph = 3; p = 0; end
             else begin ph = 1; p++; end
           end
        3: if (p == TOTAL-1) begin ph = 4; p = 0; end else p++;
        4: if (sc_ready) ph = mode_m ? 5 : 6;
        5: if (sc_ready) ph = 6;
        default: ph = 0;
      endcase
    end
  end

  // Operation statistics observed at the ports.
  int wb_cnt = 0;
  int sc_cnt = 0;
  int r1_bad = 0;
  bit inv_seen = 0;
  bit done_seen = 0;

  always @(posedge clk) begin
    if (!rst) begin
      if (wb_req && wb_ack) wb_cnt++;
      if (sc_valid && sc_ready) sc_cnt++;
      if (st_we != '0) inv_seen = 1;
      if (wb_req && inv_seen) r1_bad++;
      if (flush_done) done_seen = 1;
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (checking) begin
      chk("R3 wb_req", 32'(wb_req), 32'(ph == 2));
      if (ph == 2) begin
        chk("R5 wb_level", 32'(wb_level), 32'(p / LN));
        chk("R5 wb_index", 32'(wb_index), 32'(p % LN));
        chk("R4 wb_tag", 32'(wb_tag), 32'(mem_tag[p]));
      end
      chk("R5 st_we", 32'(st_we), (ph == 3) ? (32'd1 << (p / LN)) : 32'd0);
      chk("R7 sc_valid", 32'(sc_valid), 32'(ph == 4 || ph == 5));
      if (ph == 4) chk("R6 sc_type first", 32'(sc_type), mode_m ? 32'd1 : 32'd3);
      if (ph == 5) chk("R6 sc_type second", 32'(sc_type), 32'd2);
      chk("R8 flush_done", 32'(flush_done), 32'(ph == 6));
    end
  end

  // Handshake responders.
  int ack_rate = 1;
  int rdy_rate = 1;
  always @(negedge clk) begin
    wb_ack   <= wb_req   && ($urandom % ack_rate == 0);
    sc_ready <= sc_valid && ($urandom % rdy_rate == 0);
  end

  task automatic load(input int kind);
    for (int i = 0; i < TOTAL; i++) begin
      mem_tag[i] = TW'(i * 37 + 5);
      case (kind)
        0: mem_st[i] = (i % 3 == 0) ? 2'b11 : ((i % 3 == 1) ? 2'b01 : 2'b00);
        1: mem_st[i] = 2'b01;
        2: mem_st[i] = 2'b11;
        default: mem_st[i] = (i == 0 || i == TOTAL-1) ? 2'b11 : 2'b01;
      endcase
    end
  endtask

  function automatic int dirty_count();
    int n = 0;
    for (int i = 0; i < TOTAL; i++) if (mem_st[i] == 2'b11) n++;
    return n;
  endfunction

  task automatic run_flush(input string tag, input bit mode, input bit poke,
                           input bit flip_mode);
    int exp_wb;
    int waited;
    exp_wb = dirty_count();
    wb_cnt = 0; sc_cnt = 0; r1_bad = 0; inv_seen = 0; done_seen = 0;
    @(negedge clk);
    flush_req = 1'b1; two_cycle_mode = mode;
    @(negedge clk);
    flush_req = 1'b0;
    if (flip_mode) two_cycle_mode = ~mode;
    waited = 0;
    while (!done_seen && waited < 3000) begin
      @(negedge clk);
      waited++;
      if (poke && (waited == 5 || waited == 40)) flush_req = 1'b1;
      else flush_req = 1'b0;
    end
    flush_req = 1'b0;
    chk({"R8 done reached ", tag}, 32'(done_seen), 32'd1);
    chk({"R3 write-back count ", tag}, 32'(wb_cnt), 32'(exp_wb));
    chk({"R1 write-back after invalidate ", tag}, 32'(r1_bad), 32'd0);
    chk({"R2 lines invalid ", tag}, 32'(dirty_count() + count_valid()), 32'd0);
    chk({"R11 special cycle count ", tag}, 32'(sc_cnt), mode ? 32'd2 : 32'd1);
    repeat (6) @(negedge clk);
    chk({"R9 stays idle ", tag}, 32'(wb_req | sc_valid | (st_we != '0)), 32'd0);
  endtask

  function automatic int count_valid();
    int n = 0;
    for (int i = 0; i < TOTAL; i++) if (mem_st[i] != 2'b00) n++;
    return n;
  endfunction

  initial begin
    logic [1:0] snap [TOTAL];
    int same;
    load(0);
    repeat (3) @(negedge clk);
    chk("R10 reset wb_req", 32'(wb_req), 32'd0);
    chk("R10 reset sc_valid", 32'(sc_valid), 32'd0);
    chk("R10 reset st_we", 32'(st_we), 32'd0);
    chk("R10 reset done", 32'(flush_done), 32'd0);
    rst = 1'b0;
    checking = 1;

    load(0); ack_rate = 1; rdy_rate = 1; run_flush("mixed two", 1'b1, 1'b0, 1'b0);
    load(0); ack_rate = 3; rdy_rate = 3; run_flush("mixed one", 1'b0, 1'b0, 1'b0);
    load(1); run_flush("all clean", 1'b1, 1'b0, 1'b0);
    load(2); ack_rate = 2; run_flush("all dirty", 1'b0, 1'b0, 1'b0);
    load(3); ack_rate = 1; run_flush("ends dirty", 1'b1, 1'b0, 1'b0);
    load(2); ack_rate = 2; run_flush("R9 busy request", 1'b1, 1'b1, 1'b0);
    load(0); run_flush("R11 mode flip", 1'b1, 1'b0, 1'b1);
    load(0); run_flush("R11 mode flip one", 1'b0, 1'b0, 1'b1);

    // R10: reset in the middle of the write-back walk.
    load(2); ack_rate = 1000;
    @(negedge clk); flush_req = 1'b1; two_cycle_mode = 1'b1;
    @(negedge clk); flush_req = 1'b0;
    repeat (10) @(negedge clk);
    for (int i = 0; i < TOTAL; i++) snap[i] = mem_st[i];
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 mid reset wb_req", 32'(wb_req), 32'd0);
    chk("R10 mid reset st_we", 32'(st_we), 32'd0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    same = 0;
    for (int i = 0; i < TOTAL; i++) if (mem_st[i] == snap[i]) same++;
    chk("R10 store untouched", 32'(same), 32'(TOTAL));
    chk("R10 idle after reset", 32'(wb_req | sc_valid), 32'd0);
    ack_rate = 1;
    run_flush("after reset", 1'b0, 1'b0, 1'b0);

    checking = 0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule